// File: doc/BRIEF.md
# Randomized Backoff Retransmit Timer

This block decides when a transmitter may try again after a collision. Each attempt widens a load mask. The mask selects how many bits of a free-running pseudo-random source form the wait interval, so the possible delay roughly doubles on every retry. The interval is counted in backoff ticks. One tick is six periods of a base timer. When the interval runs out, the transmitter enable is raised. If the mask is already full when a new attempt is made, the attempt ends with a load-overflow status and nothing is sent.

During the wait the transmitter stays off. The receiver may be switched on in the meantime, but only if a receive buffer is ready. If a packet arrives during the wait, the end of the wait is dropped: the transmitter is not started and a yield status is reported instead. A `start` pulse begins a fresh packet with an empty mask, which means the first attempt goes out at once. A `collision` during transmission switches the transmitter off and runs a new, longer backoff.

Top module: `backoff_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tx_en`, `rx_en` and `status_valid` are all 0.
- R2: A `start` pulse accepted in the idle or transmitting state clears the load mask and makes an attempt. The first attempt has interval 0, so `tx_en`=1, `rx_en`=0, and `status_valid`=1 with `status_code`=0 (go) all appear at the edge that samples `start`.
- R3: Each attempt turns the mask m into (m<<1)|1. A `collision` seen in the transmitting state drops `tx_en` at that same edge and begins the next attempt, so the k-th collision after a start uses mask 2^(k+1)-1.
- R4: The interval is the low 9 bits of a 16-bit LFSR (nonzero seed, advancing every cycle), ANDed with the new mask shifted right by one. The interval is therefore always a subset of the bits of (new mask >> 1).
- R5: One tick is 6*BASE_DIV clock cycles. The interval is split into a 7-bit low part L (bits 6:0) and a 2-bit high part H (bits 8:7). The wait lasts exactly (L + 127*H) ticks, counted from the accepting edge to the edge that ends it.
- R6: An attempt with a zero interval raises `tx_en` at the accepting edge, without any wait.
- R7: During the wait `tx_en` is 0, and `rx_en` equals `rx_ready` as sampled at the accepting edge.
- R8: When the wait ends without an arrival, `tx_en` goes to 1, `rx_en` goes to 0, and a single-cycle `status_valid` pulse carries code 0 (go). `tx_en` and `rx_en` are never 1 together.
- R9: If `pkt_arrived` is high in any cycle of the wait, the end of the wait raises no `tx_en`. Instead it gives `status_code`=2 (yield), leaves `rx_en` unchanged, and returns to idle.
- R10: If the old mask has bit 15 set, the attempt gives `status_code`=1 (load overflow), forces both enables to 0, and returns to idle.
- R11: `start` is ignored during the wait, and `collision` is ignored outside the transmitting state. In both cases there is no status pulse and no change of either enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new packet with an empty mask |
| collision | input | 1 | Collision seen while transmitting |
| rx_ready | input | 1 | A receive buffer with nonzero count is set up |
| pkt_arrived | input | 1 | A packet started arriving |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| status_valid | output | 1 | One-cycle completion pulse |
| status_code | output | 2 | 0 go, 1 load overflow, 2 yield |

## Verification
The bench runs a full ladder of fifteen collisions after a start, with `rx_ready` alternating, and then a sixteenth collision that must overflow. On every rung it measures the wait in cycles. It checks that the wait is a whole number of ticks, and that the tick count can be decomposed into an interval whose bits fit inside the mask expected for that rung. This separates a correct mask growth from an off-by-one shift, and a correct tick length from a wrong prescale. A second run places `pkt_arrived` and a stray `start` inside a wait, which tells yield apart from go. Collisions in idle confirm that they are ignored.

// File: rtl/backoff_timer.sv
module backoff_timer #(
  parameter int MASK_W    = 16,
  parameter int LOW_W     = 7,
  parameter int HIGH_W    = 2,
  parameter int BASE_DIV  = 640,
  parameter int TICK_MULT = 6,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       collision,
  input  logic       rx_ready,
  input  logic       pkt_arrived,
  output logic       tx_en,
  output logic       rx_en,
  output logic       status_valid,
  output logic [1:0] status_code
);
  localparam int RND_W = LOW_W + HIGH_W;
  localparam int PRE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int SUB_W = (TICK_MULT > 1) ? $clog2(TICK_MULT) : 1;
  localparam logic [LOW_W-1:0] LOW_MAX = {LOW_W{1'b1}};
  localparam logic [1:0] ST_GO = 2'd0, ST_OVF = 2'd1, ST_YIELD = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_TX} state_t;
  state_t state;

  logic [15:0]       lfsr;
  logic [MASK_W-1:0] mask;
  logic [LOW_W-1:0]  cnt;
  logic [HIGH_W-1:0] hi;
  logic [PRE_W-1:0]  pre;
  logic [SUB_W-1:0]  sub;
  logic              arrived;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else     lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  end

  wire accept_start = start && (state != S_WAIT);
  wire accept_coll  = collision && (state == S_TX) && !start;
  wire attempt      = accept_start || accept_coll;

  wire [MASK_W-1:0] base_mask = accept_start ? '0 : mask;
  wire [MASK_W-1:0] new_mask  = {base_mask[MASK_W-2:0], 1'b1};
  wire              overflow  = base_mask[MASK_W-1];
  wire [MASK_W-1:0] limit     = new_mask >> 1;
  wire [RND_W-1:0]  ivl       = lfsr[RND_W-1:0] & limit[RND_W-1:0];
  wire [LOW_W-1:0]  ivl_lo    = ivl[LOW_W-1:0];
  wire [HIGH_W-1:0] ivl_hi    = ivl[RND_W-1:LOW_W];

  wire pre_end = (pre == PRE_W'(BASE_DIV - 1));
  wire tick    = pre_end && (sub == SUB_W'(TICK_MULT - 1));
  wire last    = (state == S_WAIT) && tick && (cnt == LOW_W'(1)) && (hi == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      mask         <= '0;
      cnt          <= '0;
      hi           <= '0;
      pre          <= '0;
      sub          <= '0;
      arrived      <= 1'b0;
      tx_en        <= 1'b0;
      rx_en        <= 1'b0;
      status_valid <= 1'b0;
      status_code  <= ST_GO;
    end else begin
      status_valid <= 1'b0;
      if (state == S_WAIT) begin
        if (pre_end) begin
          pre <= '0;
          sub <= (sub == SUB_W'(TICK_MULT - 1)) ? '0 : sub + 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
        if (pkt_arrived) arrived <= 1'b1;
        if (tick) begin
          if (cnt == LOW_W'(1)) begin
            if (hi == '0) begin
              status_valid <= 1'b1;
              if (arrived || pkt_arrived) begin
                state       <= S_IDLE;
                status_code <= ST_YIELD;
              end else begin
                state       <= S_TX;
                tx_en       <= 1'b1;
                rx_en       <= 1'b0;
                status_code <= ST_GO;
              end
            end else begin
              cnt <= LOW_MAX;
              hi  <= hi - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
      if (attempt) begin
        status_valid <= 1'b0;
        if (overflow) begin
          state        <= S_IDLE;
          tx_en        <= 1'b0;
          rx_en        <= 1'b0;
          status_valid <= 1'b1;
          status_code  <= ST_OVF;
        end else begin
          mask <= new_mask;
          if (ivl == '0) begin
            state        <= S_TX;
            tx_en        <= 1'b1;
            rx_en        <= 1'b0;
            status_valid <= 1'b1;
            status_code  <= ST_GO;
          end else begin
            state   <= S_WAIT;
            tx_en   <= 1'b0;
            rx_en   <= rx_ready;
            arrived <= 1'b0;
            pre     <= '0;
            sub     <= '0;
            if (ivl_lo == '0) begin
              cnt <= LOW_MAX;
              hi  <= ivl_hi - 1'b1;
            end else begin
              cnt <= ivl_lo;
              hi  <= ivl_hi;
            end
          end
        end
      end
    end
  end

  // R8: enables are mutually exclusive
  p_excl_en_r8: assert property (@(posedge clk) disable iff (rst)
    !(tx_en && rx_en));

  // R7: transmitter silent while waiting
  p_wait_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> !tx_en);

  // R3: a collision in transmit grows the mask by one bit
  p_mask_grow_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_TX && collision && !start && !mask[MASK_W-1])
      |=> (mask == {$past(mask[MASK_W-2:0]), 1'b1}));

  // R10: overflow leaves both enables off and the block idle
  p_ovf_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (status_valid && status_code == ST_OVF) |-> (!tx_en && !rx_en && state == S_IDLE));

  // R8: a go status always comes with the transmitter on
  p_go_tx_r8: assert property (@(posedge clk) disable iff (rst)
    (status_valid && status_code == ST_GO) |-> (tx_en && !rx_en));

  // R5: the tick counter is never empty while waiting
  p_cnt_live_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> (cnt != '0));

  // R11: nothing but the final tick leaves the wait
  p_wait_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !last) |=> (state == S_WAIT && !status_valid));
endmodule

// File: tb/backoff_timer_test.sv
module backoff_timer_test;
  localparam int TICK = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, collision = 1'b0, rx_ready = 1'b0, pkt_arrived = 1'b0;
  logic tx_en, rx_en, status_valid;
  logic [1:0] status_code;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  backoff_timer #(.BASE_DIV(1)) uut (
    .clk(clk), .rst(rst), .start(start), .collision(collision),
    .rx_ready(rx_ready), .pkt_arrived(pkt_arrived),
    .tx_en(tx_en), .rx_en(rx_en),
    .status_valid(status_valid), .status_code(status_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit fits(input int n, input int lim);
    int h, l, alt;
    h = n / 127;
    l = n % 127;
    if (h <= 3 && ((((h << 7) | l) & ~lim) == 0)) return 1'b1;
    if (l == 0 && h >= 1) begin
      alt = ((h - 1) << 7) | 127;
      if ((alt & ~lim) == 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  // drive one pulse on a chosen input; returns at the first negedge after the sampling edge
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: start = 1'b1;
      1: collision = 1'b1;
      default: pkt_arrived = 1'b1;
    endcase
    @(negedge clk);
    start = 1'b0; collision = 1'b0; pkt_arrived = 1'b0;
  endtask

  // returns cycles from accepting edge to status pulse; -1 on timeout
  task automatic wait_status(output int d);
    d = 0;
    while (!status_valid && d < 5000) begin
      @(negedge clk);
      d++;
    end
    if (!status_valid) d = -1;
  endtask

  initial begin
    int d, lim;
    bit waited;
    repeat (3) @(negedge clk);
    chk(!tx_en && !rx_en && !status_valid, "R1 reset", {tx_en, rx_en, status_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_en && !rx_en && !status_valid, "R1 after reset", {tx_en, rx_en, status_valid}, 0);

    pulse(0);
    chk(status_valid && status_code == 0, "R2 start go", {status_valid, status_code}, 4);
    chk(tx_en && !rx_en, "R6 zero interval immediate", {tx_en, rx_en}, 2);

    for (int k = 1; k <= 15; k++) begin
      rx_ready = k[0];
      pulse(1);
      lim = ((1 << k) - 1) & 9'h1FF;
      if (status_valid) begin
        chk(status_code == 0 && tx_en, "R6 immediate retry", status_code, 0);
        d = 0;
      end else begin
        chk(!tx_en, "R3 collision drops tx", tx_en, 0);
        chk(rx_en == rx_ready, "R7 rx during wait", rx_en, rx_ready);
        wait_status(d);
        chk(d > 0, "R5 wait ends", d, 1);
        chk(d % TICK == 0, "R5 whole ticks", d, (d / TICK) * TICK);
        chk(status_code == 0, "R8 go code", status_code, 0);
        chk(tx_en && !rx_en, "R8 enables after wait", {tx_en, rx_en}, 2);
      end
      chk(fits(d / TICK, lim), "R4 interval inside mask", d / TICK, lim);
    end

    pulse(1);
    chk(status_valid && status_code == 1, "R10 overflow status", status_code, 1);
    chk(!tx_en && !rx_en, "R10 enables off", {tx_en, rx_en}, 0);

    pulse(1);
    chk(!status_valid && !tx_en && !rx_en, "R11 collision ignored in idle",
        {status_valid, tx_en, rx_en}, 0);

    pulse(0);
    chk(status_valid && status_code == 0 && tx_en, "R2 restart after overflow", status_code, 0);

    rx_ready = 1'b1;
    waited = 1'b0;
    for (int k = 1; k <= 14 && !waited; k++) begin
      pulse(1);
      if (!status_valid) begin
        waited = 1'b1;
        @(negedge clk);
        pkt_arrived = 1'b1;
        @(negedge clk);
        pkt_arrived = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!status_valid || status_code == 2, "R11 start ignored in wait", status_code, 2);
        chk(!tx_en && rx_en, "R11 enables unchanged", {tx_en, rx_en}, 1);
        wait_status(d);
        chk(d >= 0 && status_code == 2, "R9 yield code", status_code, 2);
        chk(!tx_en && rx_en, "R9 no transmit, rx kept", {tx_en, rx_en}, 1);
      end
    end
    chk(waited, "R9 a wait occurred", waited, 1);

    pulse(0);
    chk(status_valid && status_code == 0 && tx_en && !rx_en, "R2 start from idle after yield",
        {tx_en, rx_en}, 2);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule